// File: doc/BRIEF.md
# Reset/Sync Pulse Classifier with Power and MAC Clock Control

This block sits between the MAC and the line side of a 10/100 Ethernet physical layer device. It watches one input pin that carries both reset and synchronisation, and it measures how long each pulse on that pin lasts, in ticks of the base clock. Very short pulses are treated as noise and dropped. Pulses of moderate length produce a one-cycle sync event. A pulse that is held long enough triggers a full internal reset.

The block also holds control register 0 of the management space. Bit 15 of that register is a software reset trigger that clears itself. Bit 11 enables reduced power. The reduced-power state used by the block is the OR of bit 11 and an external power-down request.

The block drives the MAC interface clock without ever stopping it. When the link runs at 100 Mb/s and reduced power is off, this clock runs at the base rate. In every other case it runs at one tenth of the base rate. A change of rate is applied only when both candidate clocks are low, so no short high or low phase appears on the output.

Top module: `lanc_rst_pwr`

## Requirements
- R1: A pin pulse lasting fewer than SHORT_TICKS (default 10) base-clock cycles produces neither a sync event nor a reset.
- R2: A pin pulse held for LONG_TICKS (default 25000) cycles or more raises `core_reset_o` for RESET_HOLD (default 8) cycles. It raises no sync event.
- R3: A pin pulse lasting from SHORT_TICKS to LONG_TICKS-1 cycles raises `sync_evt_o` for exactly one cycle after the pulse is released. It does not reset the block, and register 0 keeps its value.
- R4: Writing register 0 with bit 15 = 1 starts the same internal reset as R2. Bit 15 reads 1 while that reset is running and reads 0 once it has finished.
- R5: Bit 11 of register 0 can be read and written and resets to 0. Every other bit of `reg_rdata_o` reads 0, except bit 15 as described in R4.
- R6: `low_power_o` equals bit 11 of register 0 ORed with `pwr_down_i`.
- R7: When `speed_100_i` = 1 and `low_power_o` = 0, `mac_clk_o` runs at the base clock rate. When `speed_100_i` = 0, it runs at the base rate divided by DIV_RATIO (default 10).
- R8: While `low_power_o` = 1, `mac_clk_o` runs at base/DIV_RATIO whatever the value of `speed_100_i`. The clock keeps running during an internal reset.
- R9: A change of clock rate never produces a high or low phase on `mac_clk_o` shorter than half a base-clock period.
- R10: After any internal reset, whether it came from the pin or from bit 15, register 0 holds its default value of 0x0000. It also holds that value during the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| pin_rs_i | input | 1 | Combined reset/sync pin, asynchronous, active high |
| pwr_down_i | input | 1 | External power-down request |
| speed_100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| reg_we_i | input | 1 | One-cycle write strobe for register 0 |
| reg_wdata_i | input | 16 | Write data for register 0 |
| reg_rdata_o | output | 16 | Read value of register 0 |
| sync_evt_o | output | 1 | One-cycle sync indication |
| core_reset_o | output | 1 | Internal reset in progress |
| low_power_o | output | 1 | Effective reduced-power state |
| mac_clk_o | output | 1 | Interface clock to the MAC |

## Verification
The pin is driven with pulses of 3, 9, 10, 24999 and 25000 cycles. These widths sit on each side of both thresholds, so each one separates the ignore, sync and reset outcomes at the exact tick where the outcome changes. A scoreboard queues the event expected from each pulse and from each software reset, and it flags any event that was not expected.

The MAC clock is sampled by counting its edges over a fixed window in four settings: full speed, low speed, power-down input, and power bit set. This tells apart the rate chosen by speed from the rate forced by power. The clock edges are also counted through a software reset, which shows that the clock keeps running. A monitor of the minimum phase length, active across all rate changes, catches any glitch.

// File: rtl/lanc_pkg.sv
package lanc_pkg;
  localparam int REG_W       = 16;
  localparam int RST_BIT     = 15;
  localparam int LP_BIT      = 11;

  typedef struct packed {
    logic rst_busy;
    logic low_pwr;
  } ctrl_t;
endpackage

// File: rtl/lanc_pulse_class.sv
module lanc_pulse_class #(
  parameter int SHORT_TICKS = 10,
  parameter int LONG_TICKS  = 25000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic sync_o,
  output logic long_o
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_TICKS);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_TICKS);
  localparam logic [CW-1:0] LAST_C  = CW'(LONG_TICKS - 1);

  logic [SYNC_STAGES-1:0] sr_q;
  logic                   pin_s;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SYNC_STAGES-2:0], pin_i};
  end
  assign pin_s = sr_q[SYNC_STAGES-1];

  // width counter saturates at LONG so a held pin fires only once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_o <= 1'b0;
      long_o <= 1'b0;
    end else begin
      sync_o <= !pin_s && (cnt_q >= SHORT_C) && (cnt_q < LONG_C);
      long_o <= pin_s && (cnt_q == LAST_C);
      if (pin_s) begin
        if (cnt_q != LONG_C) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/lanc_ctrl_reg.sv
module lanc_ctrl_reg
  import lanc_pkg::*;
#(
  parameter int RESET_HOLD = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             long_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output ctrl_t            ctrl_o
);
  localparam int HW = $clog2(RESET_HOLD + 1);
  localparam logic [HW-1:0] HOLD_C = HW'(RESET_HOLD);

  logic [HW-1:0] hold_q;
  logic          lp_q;
  logic          busy;
  logic          trig;

  assign busy = (hold_q != '0);
  assign trig = long_i || (we_i && wdata_i[RST_BIT] && !busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      lp_q   <= 1'b0;
    end else begin
      if (trig)      hold_q <= HOLD_C;
      else if (busy) hold_q <= hold_q - 1'b1;
      // register held at default while reset runs; writes dropped
      if (trig || busy) lp_q <= 1'b0;
      else if (we_i)    lp_q <= wdata_i[LP_BIT];
    end
  end

  always_comb begin
    rdata_o         = '0;
    rdata_o[RST_BIT] = busy;
    rdata_o[LP_BIT]  = lp_q;
  end

  assign ctrl_o.rst_busy = busy;
  assign ctrl_o.low_pwr  = lp_q;
endmodule

// File: rtl/lanc_clk_sel.sv
module lanc_clk_sel #(
  parameter int DIV_RATIO = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_fast_i,
  output logic slow_o,
  output logic mac_clk_o
);
  localparam int DW = $clog2(DIV_RATIO);
  localparam logic [DW-1:0] LAST_C = DW'(DIV_RATIO - 1);
  localparam logic [DW-1:0] HALF_C = DW'(DIV_RATIO / 2);

  logic [DW-1:0] div_q;
  logic [DW-1:0] div_n;
  logic          slow_q;
  logic          fast_q;

  assign div_n = (div_q == LAST_C) ? '0 : div_q + 1'b1;

  // free running; only the power-on reset touches it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= LAST_C;
      slow_q <= 1'b0;
    end else begin
      div_q  <= div_n;
      slow_q <= (div_n < HALF_C);
    end
  end

  // select changes on the falling edge at the end of the slow low phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fast_q <= 1'b0;
    else if (div_q == LAST_C)   fast_q <= want_fast_i;
  end

  assign slow_o    = slow_q;
  assign mac_clk_o = fast_q ? clk_i : slow_q;
endmodule

// File: rtl/lanc_rst_pwr.sv
module lanc_rst_pwr
  import lanc_pkg::*;
#(
  parameter int SHORT_TICKS = 10,
  parameter int LONG_TICKS  = 25000,
  parameter int SYNC_STAGES = 2,
  parameter int RESET_HOLD  = 8,
  parameter int DIV_RATIO   = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_rs_i,
  input  logic        pwr_down_i,
  input  logic        speed_100_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        sync_evt_o,
  output logic        core_reset_o,
  output logic        low_power_o,
  output logic        mac_clk_o
);
  logic  long_hit;
  logic  slow_clk;
  ctrl_t ctrl;

  lanc_pulse_class #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_class (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_rs_i),
    .sync_o(sync_evt_o),
    .long_o(long_hit)
  );

  lanc_ctrl_reg #(
    .RESET_HOLD(RESET_HOLD)
  ) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .long_i (long_hit),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ctrl_o (ctrl)
  );

  assign core_reset_o = ctrl.rst_busy;
  assign low_power_o  = ctrl.low_pwr | pwr_down_i;

  lanc_clk_sel #(
    .DIV_RATIO(DIV_RATIO)
  ) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .want_fast_i(speed_100_i && !low_power_o),
    .slow_o     (slow_clk),
    .mac_clk_o  (mac_clk_o)
  );
endmodule

// File: rtl/lanc_rst_pwr_chk.sv
module lanc_rst_pwr_chk #(
  parameter int SHORT_TICKS = 10,
  parameter int LONG_TICKS  = 25000,
  parameter int DIV_RATIO   = 10
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pin_rs_i,
  input logic        pwr_down_i,
  input logic [15:0] reg_rdata_o,
  input logic        sync_evt_o,
  input logic        core_reset_o,
  input logic        low_power_o,
  input logic        slow_clk_i
);
  localparam int CW = $clog2(LONG_TICKS + 2);
  localparam int RW = $clog2(DIV_RATIO + 2);

  logic [1:0]    ps_q;
  logic [CW-1:0] run_q, last_q;
  logic [RW-1:0] ph_q;
  logic          slow_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q <= '0; run_q <= '0; last_q <= '0; ph_q <= '0; slow_d <= 1'b0;
    end else begin
      ps_q <= {ps_q[0], pin_rs_i};
      if (ps_q[1]) begin
        if (run_q != CW'(LONG_TICKS + 1)) run_q <= run_q + 1'b1;
      end else if (run_q != '0) begin
        last_q <= run_q;
        run_q  <= '0;
      end
      slow_d <= slow_clk_i;
      ph_q   <= (slow_clk_i != slow_d) ? RW'(1) : ph_q + 1'b1;
    end
  end

  a_r1_sync_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt_o |-> (last_q >= CW'(SHORT_TICKS)) && (last_q < CW'(LONG_TICKS)));
  a_r3_sync_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_evt_o |=> !sync_evt_o);
  a_r6_lp_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_o == (reg_rdata_o[11] | pwr_down_i));
  a_r10_default_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_reset_o |-> !reg_rdata_o[11]);
  a_r9_slow_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= RW'(DIV_RATIO / 2));
endmodule

bind lanc_rst_pwr lanc_rst_pwr_chk #(
  .SHORT_TICKS(SHORT_TICKS),
  .LONG_TICKS (LONG_TICKS),
  .DIV_RATIO  (DIV_RATIO)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pin_rs_i    (pin_rs_i),
  .pwr_down_i  (pwr_down_i),
  .reg_rdata_o (reg_rdata_o),
  .sync_evt_o  (sync_evt_o),
  .core_reset_o(core_reset_o),
  .low_power_o (low_power_o),
  .slow_clk_i  (slow_clk)
);

// File: tb/lanc_rst_pwr_bench.sv
`timescale 1ns/1ps
module lanc_rst_pwr_bench;
  localparam int HOLD = 8;
  localparam int EV_SYNC = 1;
  localparam int EV_RST  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0, pwr_dn = 1'b0, spd = 1'b0, we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sync_evt, core_rst, low_pwr, mac_clk;

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  int edge_cnt = 0;
  bit glitch_on = 1'b0, glitch_seen = 1'b0;
  realtime last_t = 0.0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lanc_rst_pwr u_lanc_rst_pwr (
    .clk_i(clk), .rst_ni(rst_n), .pin_rs_i(pin), .pwr_down_i(pwr_dn),
    .speed_100_i(spd), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sync_evt_o(sync_evt), .core_reset_o(core_rst),
    .low_power_o(low_pwr), .mac_clk_o(mac_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected events as the design raises them
  logic rst_prev = 1'b0;
  always @(negedge clk) begin
    int got;
    got = 0;
    if (sync_evt) got = EV_SYNC;
    if (core_rst && !rst_prev) got = EV_RST;
    rst_prev = core_rst;
    if (got != 0) begin
      if (exp_q.size() == 0) check(1'b0, "R1/R2/R3 unexpected event", got, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(got == e, "R2/R3 event kind", got, e);
      end
    end
  end

  always @(posedge mac_clk) edge_cnt++;
  always @(mac_clk) begin
    if (glitch_on && last_t > 0.0 && ($realtime - last_t) < 3.9) glitch_seen = 1'b1;
    last_t = $realtime;
  end

  task automatic pulse(input int w, input int ev, input string req);
    if (ev != 0) exp_q.push_back(ev);
    @(negedge clk); pin = 1'b1;
    repeat (w) @(negedge clk);
    pin = 1'b0;
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic measure(input int exp, input string req);
    repeat (30) @(negedge clk);
    edge_cnt = 0;
    repeat (100) @(negedge clk);
    check(edge_cnt == exp, req, edge_cnt, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    glitch_on = 1'b1;
    check(rdata == 16'h0000, "R5 reset value", rdata, 0);
    check(!core_rst, "R2 idle reset", core_rst, 0);
    check(!low_pwr, "R6 idle power", low_pwr, 0);

    spd = 1'b1; measure(100, "R7 fast clock");
    spd = 1'b0; measure(10, "R7 slow clock");
    spd = 1'b1; pwr_dn = 1'b1;
    @(negedge clk);
    check(low_pwr, "R6 pin merge", low_pwr, 1);
    measure(10, "R8 power-down slow");
    pwr_dn = 1'b0;
    wr(16'h0800);
    check(rdata == 16'h0800, "R5 bit11 write", rdata, 16'h0800);
    check(low_pwr, "R6 bit merge", low_pwr, 1);
    measure(10, "R8 bit11 slow");
    wr(16'h0000);
    check(!low_pwr, "R6 cleared", low_pwr, 0);
    measure(100, "R9 back to fast");

    pulse(3, 0, "R1 3-tick glitch");
    pulse(9, 0, "R1 9-tick glitch");
    wr(16'h0800);
    pulse(10, EV_SYNC, "R3 10-tick sync");
    pulse(24999, EV_SYNC, "R3 24999-tick sync");
    check(rdata[11] == 1'b1, "R3 register kept", rdata[11], 1);
    pulse(25000, EV_RST, "R2 25000-tick reset");
    check(rdata == 16'h0000, "R10 default after pin reset", rdata, 0);

    wr(16'h0800);
    exp_q.push_back(EV_RST);
    @(negedge clk); we = 1'b1; wdata = 16'h8800;
    @(negedge clk); we = 1'b0;
    check(rdata[15] && core_rst, "R4 bit15 busy", rdata[15], 1);
    repeat (HOLD) @(negedge clk);
    check(rdata == 16'h0000, "R4 R10 self clear", rdata, 0);
    check(exp_q.size() == 0, "R4 reset event", exp_q.size(), 0);

    exp_q.push_back(EV_RST);
    edge_cnt = 0;
    wr(16'h8000);
    repeat (18) @(negedge clk);
    check(edge_cnt == 20, "R8 clock runs in reset", edge_cnt, 20);
    check(glitch_seen == 1'b0, "R9 no short phase", glitch_seen, 0);
    check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule